// File: doc/BRIEF.md
# Six-Bank Polynomial Memory File with Instruction Executor

This block holds six polynomials over the integers modulo a prime Q. Each has n coefficients, stored two to a word, so each bank is n/2 words deep and two coefficients wide. A small executor accepts one instruction at a time. Each instruction names a source bank pair and a destination bank. The executor then sweeps every word of the polynomial in order. It can fill a bank from a coefficient-pair stream, fill a bank from a message bit stream through an encoder, add two banks lane by lane modulo Q, or multiply two banks coefficient by coefficient modulo Q.

All six banks share one read address, one write address and one write data bus. A bank index picks which bank takes the write, and a single output multiplexer picks which bank's word is read. The banks therefore behave as one memory with one read and one write per cycle. A two-operand instruction reads the same word twice: the first source in one cycle and the second in the next. It writes the result one cycle after the second read. When the executor is idle, the read port belongs to the read-out interface, so any word of any bank can be inspected.

Top module: `polyFile`

## Requirements
- R1: After reset, instBusy and instDone are low.
- R2: An instruction is taken when instValid is high while instBusy is low. instOp encodes LOAD=0, ENCODE=1, ADD=2, MUL=3. LOAD writes each pair presented with loadValid to the next word of bank wrIdx, starting at word 0. loadLo is coefficient 2w and loadHi is coefficient 2w+1. After word n/2-1 is written, instDone pulses in the next cycle and instBusy falls.
- R3: ENCODE takes one bit per cycle while msgValid is high and writes coefficient (Q-1)/2 for a 1 and 0 for a 0. The first bit of each pair goes to the low lane. A bank holds bits 0 to n-1 in order.
- R4: ADD writes (a+b) mod Q into each lane of bank wrIdx, where a comes from bank rdIdx0 and b from bank rdIdx1. This holds when the sum reaches or exceeds Q.
- R5: MUL writes (a*b) mod Q into each lane of bank wrIdx, with a and b taken as in R4.
- R6: For ADD and MUL, instBusy stays high for exactly n+1 cycles, starting in the cycle after acceptance. instDone is high for exactly one cycle: the first cycle with instBusy low.
- R7: instValid while instBusy is high is ignored. The running instruction keeps its timing, and no bank it does not target changes.
- R8: An instruction with rdIdx0, rdIdx1 or wrIdx of 6 or 7 is not accepted. instBusy stays low and no bank changes.
- R9: An instruction changes only its destination bank. All other banks keep their contents.
- R10: While idle, outLo/outHi show the word of bank outSel at word outAddr, one cycle after these are applied.
- R11: ADD or MUL with the destination equal to a source bank gives the same result as with a separate destination.
- R12: During LOAD, a cycle with loadValid low writes nothing and does not advance the word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction request |
| instOp | input | 2 | Opcode: 0 LOAD, 1 ENCODE, 2 ADD, 3 MUL |
| rdIdx0 | input | 3 | First source bank |
| rdIdx1 | input | 3 | Second source bank |
| wrIdx | input | 3 | Destination bank |
| instBusy | output | 1 | Instruction in progress |
| instDone | output | 1 | One-cycle completion pulse |
| loadValid | input | 1 | Coefficient pair present (LOAD) |
| loadLo | input | CW (13) | Even-index coefficient |
| loadHi | input | CW (13) | Odd-index coefficient |
| msgValid | input | 1 | Message bit present (ENCODE) |
| msgBit | input | 1 | Message bit |
| outSel | input | 3 | Bank for read-out |
| outAddr | input | log2(n/2) (3) | Word for read-out |
| outLo | output | CW (13) | Low lane of the read word |
| outHi | output | CW (13) | High lane of the read word |

## Verification
The arithmetic is exercised on three kinds of data: uniformly random residues, banks filled entirely with Q-1, and encoded message banks that hold only 0 and (Q-1)/2. Random data shows that both lanes and both operand orders are handled. The all-(Q-1) banks force every addition across the modulus, which separates a correct reduction from a missing or doubled one. The encoded banks pair a zero operand with a large one, which exposes swapped lanes and a mis-routed second operand. An in-place add on the saturated bank, a stalled load, a request injected mid-run, and out-of-range bank indices cover the ordering and rejection rules.

// File: rtl/polyPkg.sv
package polyPkg;
  localparam int NUM_MEM = 6;
  localparam int IDX_W   = 3;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_ENCODE = 2'd1,
    OP_ADD    = 2'd2,
    OP_MUL    = 2'd3
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_LOAD = 2'd0,
    SRC_ENC  = 2'd1,
    SRC_ADD  = 2'd2,
    SRC_MUL  = 2'd3
  } wrSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [IDX_W-1:0] rdSel;   // bank routed through the output mux
    logic             latchA;  // capture first operand
    logic             capLow;  // capture encoded low lane
    logic             wrEn;    // write the shared data bus
    logic [IDX_W-1:0] wrSel;   // bank receiving the write
    wrSrc_e           wrSrc;   // what drives the write bus
  } strobe_t;
endpackage

// File: rtl/polyLaneAlu.sv
module polyLaneAlu #(
  parameter int Q  = 7681,
  parameter int CW = 13
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  input  logic          isMul,
  output logic [CW-1:0] res
);
  localparam int PW = 2 * CW;

  logic [CW:0]   sum;
  logic [CW:0]   sumRed;
  logic [PW-1:0] prod;
  logic [PW-1:0] prodRed;

  always_comb begin
    sum     = {1'b0, a} + {1'b0, b};
    sumRed  = (sum >= (CW+1)'(Q)) ? (sum - (CW+1)'(Q)) : sum;
    prod    = PW'(a) * PW'(b);
    prodRed = prod % PW'(Q);
    res     = isMul ? prodRed[CW-1:0] : sumRed[CW-1:0];
  end
endmodule

// File: rtl/polyDatapath.sv
module polyDatapath
  import polyPkg::*;
#(
  parameter int N  = 16,
  parameter int Q  = 7681,
  parameter int CW = 13,
  localparam int DEPTH = N / 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] loadLo,
  input  logic [CW-1:0] loadHi,
  input  logic          msgBit,
  output logic [CW-1:0] rdLo,
  output logic [CW-1:0] rdHi
);
  localparam int WW = 2 * CW;
  localparam logic [CW-1:0] HALF = CW'((Q - 1) / 2);

  logic [NUM_MEM-1:0][WW-1:0] bankOut;
  logic [WW-1:0] rdWord;
  logic [WW-1:0] opA;
  logic [WW-1:0] arithWord;
  logic [WW-1:0] wrWord;
  logic [CW-1:0] encBit;
  logic [CW-1:0] lowReg;

  // six banks sharing address and data; only the enable is per bank
  for (genvar g = 0; g < NUM_MEM; g++) begin : gBank
    logic [WW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.wrSel == IDX_W'(g)) mem[wrAddr] <= wrWord;
    end
    assign bankOut[g] = mem[rdAddr];
  end

  // single output multiplexer, registered
  always_ff @(posedge clk) begin
    if (!rstN) rdWord <= '0;
    else if (strb.rdSel < IDX_W'(NUM_MEM)) rdWord <= bankOut[strb.rdSel];
    else rdWord <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA    <= '0;
      lowReg <= '0;
    end else begin
      if (strb.latchA) opA <= rdWord;
      if (strb.capLow) lowReg <= encBit;
    end
  end

  assign encBit = msgBit ? HALF : '0;

  for (genvar l = 0; l < 2; l++) begin : gLane
    polyLaneAlu #(.Q(Q), .CW(CW)) uAlu (
      .a    (opA[l*CW +: CW]),
      .b    (rdWord[l*CW +: CW]),
      .isMul(strb.wrSrc == SRC_MUL),
      .res  (arithWord[l*CW +: CW])
    );
  end

  always_comb begin
    unique case (strb.wrSrc)
      SRC_LOAD: wrWord = {loadHi, loadLo};
      SRC_ENC:  wrWord = {encBit, lowReg};
      default:  wrWord = arithWord;
    endcase
  end

  assign rdLo = rdWord[CW-1:0];
  assign rdHi = rdWord[WW-1:CW];

  AST_ENC_VALUES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrSrc == SRC_ENC) |->
      ((wrWord[CW-1:0] == '0 || wrWord[CW-1:0] == HALF) &&
       (wrWord[WW-1:CW] == '0 || wrWord[WW-1:CW] == HALF))); // R3
  AST_ARITH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && (strb.wrSrc == SRC_ADD || strb.wrSrc == SRC_MUL) &&
     opA[CW-1:0] < CW'(Q) && rdWord[CW-1:0] < CW'(Q)) |->
      (wrWord[CW-1:0] < CW'(Q))); // R4
  AST_WR_BANK: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (strb.wrSel < IDX_W'(NUM_MEM))); // R8
endmodule

// File: rtl/polyControl.sv
module polyControl
  import polyPkg::*;
#(
  parameter int N = 16,
  localparam int DEPTH = N / 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [1:0]       instOp,
  input  logic [IDX_W-1:0] rdIdx0,
  input  logic [IDX_W-1:0] rdIdx1,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             loadValid,
  input  logic             msgValid,
  input  logic [IDX_W-1:0] outSel,
  input  logic [AW-1:0]    outAddr,
  output logic             busy,
  output logic             done,
  output strobe_t          strb,
  output logic [AW-1:0]    rdAddr,
  output logic [AW-1:0]    wrAddr
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ENC, ST_ARITH} state_e;

  state_e           state;
  opcode_e          opReg;
  logic [IDX_W-1:0] srcA, srcB, dst;
  logic [AW-1:0]    cnt, addrD;
  logic             phase, issuing, p0d, p1d, doneReg;
  logic             badIdx, accept, lastWord;

  assign badIdx   = (rdIdx0 >= IDX_W'(NUM_MEM)) || (rdIdx1 >= IDX_W'(NUM_MEM)) ||
                    (wrIdx >= IDX_W'(NUM_MEM));
  assign accept   = instValid && (state == ST_IDLE) && !badIdx;
  assign lastWord = (cnt == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_LOAD;
      srcA    <= '0;
      srcB    <= '0;
      dst     <= '0;
      cnt     <= '0;
      addrD   <= '0;
      phase   <= 1'b0;
      issuing <= 1'b0;
      p0d     <= 1'b0;
      p1d     <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      p0d     <= (state == ST_ARITH) && issuing && !phase;
      p1d     <= (state == ST_ARITH) && issuing && phase;
      addrD   <= cnt;
      unique case (state)
        ST_IDLE: if (accept) begin
          opReg <= opcode_e'(instOp);
          srcA  <= rdIdx0;
          srcB  <= rdIdx1;
          dst   <= wrIdx;
          cnt   <= '0;
          phase <= 1'b0;
          unique case (opcode_e'(instOp))
            OP_LOAD:   state <= ST_LOAD;
            OP_ENCODE: state <= ST_ENC;
            default: begin
              state   <= ST_ARITH;
              issuing <= 1'b1;
            end
          endcase
        end
        ST_LOAD: if (loadValid) begin
          cnt <= cnt + 1'b1;
          if (lastWord) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        ST_ENC: if (msgValid) begin
          phase <= ~phase;
          if (phase) begin
            cnt <= cnt + 1'b1;
            if (lastWord) begin
              state   <= ST_IDLE;
              doneReg <= 1'b1;
            end
          end
        end
        ST_ARITH: begin
          if (issuing) begin
            phase <= ~phase;
            if (phase) begin
              cnt <= cnt + 1'b1;
              if (lastWord) issuing <= 1'b0;
            end
          end
          if (p1d && addrD == AW'(DEPTH - 1)) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.wrSel  = dst;
    strb.latchA = p0d;
    unique case (opReg)
      OP_LOAD:   strb.wrSrc = SRC_LOAD;
      OP_ENCODE: strb.wrSrc = SRC_ENC;
      OP_ADD:    strb.wrSrc = SRC_ADD;
      default:   strb.wrSrc = SRC_MUL;
    endcase
    if (state == ST_ARITH) begin
      rdAddr     = cnt;
      strb.rdSel = phase ? srcB : srcA;
      wrAddr     = addrD;
      strb.wrEn  = p1d;
    end else begin
      rdAddr      = outAddr;
      strb.rdSel  = outSel;
      wrAddr      = cnt;
      strb.wrEn   = ((state == ST_LOAD) && loadValid) ||
                    ((state == ST_ENC) && msgValid && phase);
      strb.capLow = (state == ST_ENC) && msgValid && !phase;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && instValid) |=> ($stable(dst) && $stable(srcA) && $stable(srcB))); // R7
  AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && instValid && badIdx) |=> !busy); // R8
endmodule

// File: rtl/polyFile.sv
module polyFile
  import polyPkg::*;
#(
  parameter int N  = 16,
  parameter int Q  = 7681,
  parameter int CW = $clog2(Q),
  localparam int DEPTH = N / 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [1:0]    instOp,
  input  logic [2:0]    rdIdx0,
  input  logic [2:0]    rdIdx1,
  input  logic [2:0]    wrIdx,
  output logic          instBusy,
  output logic          instDone,
  input  logic          loadValid,
  input  logic [CW-1:0] loadLo,
  input  logic [CW-1:0] loadHi,
  input  logic          msgValid,
  input  logic          msgBit,
  input  logic [2:0]    outSel,
  input  logic [AW-1:0] outAddr,
  output logic [CW-1:0] outLo,
  output logic [CW-1:0] outHi
);
  strobe_t       strb;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] wrAddr;

  polyControl #(.N(N)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instOp   (instOp),
    .rdIdx0   (rdIdx0),
    .rdIdx1   (rdIdx1),
    .wrIdx    (wrIdx),
    .loadValid(loadValid),
    .msgValid (msgValid),
    .outSel   (outSel),
    .outAddr  (outAddr),
    .busy     (instBusy),
    .done     (instDone),
    .strb     (strb),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr)
  );

  polyDatapath #(.N(N), .Q(Q), .CW(CW)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdAddr(rdAddr),
    .wrAddr(wrAddr),
    .loadLo(loadLo),
    .loadHi(loadHi),
    .msgBit(msgBit),
    .rdLo  (outLo),
    .rdHi  (outHi)
  );
endmodule

// File: tb/polyFile_bench.sv
`timescale 1ns/1ps
module polyFile_bench;
  localparam int N = 16;
  localparam int Q = 7681;
  localparam int CW = $clog2(Q);
  localparam int DEPTH = N / 2;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [1:0] instOp = '0;
  logic [2:0] rdIdx0 = '0, rdIdx1 = '0, wrIdx = '0;
  logic instBusy, instDone;
  logic loadValid = 1'b0;
  logic [CW-1:0] loadLo = '0, loadHi = '0;
  logic msgValid = 1'b0, msgBit = 1'b0;
  logic [2:0] outSel = '0;
  logic [AW-1:0] outAddr = '0;
  logic [CW-1:0] outLo, outHi;

  always #2.5 clk = ~clk;

  polyFile #(.N(N), .Q(Q)) u_polyFile (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .rdIdx0(rdIdx0), .rdIdx1(rdIdx1), .wrIdx(wrIdx),
    .instBusy(instBusy), .instDone(instDone),
    .loadValid(loadValid), .loadLo(loadLo), .loadHi(loadHi),
    .msgValid(msgValid), .msgBit(msgBit),
    .outSel(outSel), .outAddr(outAddr), .outLo(outLo), .outHi(outHi)
  );

  int errors = 0;
  int checks = 0;
  int model [6][N];
  bit known [6];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock relation between the two status outputs (R6)
  always @(negedge clk) begin
    if (rstN && instDone) check(!instBusy, "R6 done-with-busy", int'(instBusy), 0);
  end

  task automatic issue(input int op, input int r0, input int r1, input int w);
    @(negedge clk);
    instValid = 1'b1; instOp = op[1:0];
    rdIdx0 = r0[2:0]; rdIdx1 = r1[2:0]; wrIdx = w[2:0];
    @(negedge clk);
    instValid = 1'b0;
  endtask

  // mode 0: random residues, mode 1: all Q-1
  task automatic loadBank(input int w, input int mode, input bit gaps);
    issue(0, 0, 0, w);
    check(instBusy == 1'b1, "R2 busy after accept", int'(instBusy), 1);
    for (int i = 0; i < DEPTH; i++) begin
      int lo, hi;
      if (gaps && (i % 3 == 1)) begin
        loadValid = 1'b0; loadLo = '1; loadHi = '1;
        @(negedge clk);
        check(instBusy == 1'b1 && instDone == 1'b0, "R12 stall holds", int'(instBusy), 1);
      end
      lo = (mode == 1) ? Q - 1 : int'($urandom % Q);
      hi = (mode == 1) ? Q - 1 : int'($urandom % Q);
      loadValid = 1'b1; loadLo = CW'(lo); loadHi = CW'(hi);
      model[w][2*i] = lo; model[w][2*i+1] = hi;
      @(negedge clk);
    end
    loadValid = 1'b0;
    check(instDone == 1'b1 && instBusy == 1'b0, "R2 done after last pair", int'(instDone), 1);
    known[w] = 1'b1;
  endtask

  task automatic encodeBank(input int w, input logic [N-1:0] bits);
    issue(1, 0, 0, w);
    for (int i = 0; i < N; i++) begin
      msgValid = 1'b1; msgBit = bits[i];
      model[w][i] = bits[i] ? (Q - 1) / 2 : 0;
      @(negedge clk);
    end
    msgValid = 1'b0;
    check(instDone == 1'b1 && instBusy == 1'b0, "R3 done after last bit", int'(instDone), 1);
    known[w] = 1'b1;
  endtask

  task automatic arith(input int op, input int a, input int b, input int w,
                       input bit inject, input string req);
    issue(op, a, b, w);
    for (int k = 1; k <= N + 1; k++) begin
      check(instBusy == 1'b1, "R6 busy window", int'(instBusy), 1);
      if (inject && k == 3) begin
        instValid = 1'b1; instOp = 2'd0; rdIdx0 = 3'd0; rdIdx1 = 3'd0; wrIdx = 3'd5;
      end
      if (inject && k == 4) instValid = 1'b0;
      @(negedge clk);
    end
    check(instBusy == 1'b0 && instDone == 1'b1, "R6 end of window", int'(instDone), 1);
    for (int i = 0; i < N; i++) begin
      if (op == 2) model[w][i] = (model[a][i] + model[b][i]) % Q;
      else         model[w][i] = (model[a][i] * model[b][i]) % Q;
    end
    known[w] = 1'b1;
    @(negedge clk);
    check(instDone == 1'b0 && instBusy == 1'b0, {req, " R6 done single"}, int'(instDone), 0);
  endtask

  task automatic readAll(input string req);
    for (int m = 0; m < 6; m++) begin
      if (known[m]) begin
        for (int a = 0; a < DEPTH; a++) begin
          outSel = 3'(m); outAddr = AW'(a);
          @(negedge clk);
          check(int'(outLo) == model[m][2*a], req, int'(outLo), model[m][2*a]);
          check(int'(outHi) == model[m][2*a+1], req, int'(outHi), model[m][2*a+1]);
        end
      end
    end
  endtask

  task automatic badIssue(input int r1, input int w);
    issue(2, 0, r1, w);
    check(instBusy == 1'b0, "R8 index rejected", int'(instBusy), 0);
    @(negedge clk);
    check(instBusy == 1'b0 && instDone == 1'b0, "R8 stays idle", int'(instBusy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 6; m++) known[m] = 1'b0;
    repeat (3) @(negedge clk);
    check(instBusy == 1'b0, "R1 busy in reset", int'(instBusy), 0);
    check(instDone == 1'b0, "R1 done in reset", int'(instDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(instBusy == 1'b0 && instDone == 1'b0, "R1 idle after reset", int'(instBusy), 0);

    loadBank(0, 0, 1'b1);            // R12 stalls inside
    loadBank(1, 0, 1'b0);
    loadBank(2, 1, 1'b0);
    readAll("R2 load contents R10");

    encodeBank(5, 16'hA5C3);
    readAll("R3 encoded contents");

    arith(2, 0, 1, 4, 1'b0, "R4");
    readAll("R4 add random R9");

    arith(3, 0, 1, 3, 1'b1, "R5");   // R7 request injected mid-run
    readAll("R5 mul random R7 R9");

    arith(2, 2, 2, 2, 1'b0, "R11");
    readAll("R11 in-place add wraps");

    arith(3, 5, 2, 3, 1'b0, "R5");
    readAll("R5 mul encoded by saturated");

    arith(2, 4, 5, 4, 1'b0, "R11");
    readAll("R11 in-place add with encoded");

    badIssue(0, 6);
    badIssue(7, 1);
    readAll("R8 banks unchanged");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule